// File: doc/BRIEF.md
# Ping-Pong OUT Pipe Bank Controller

This block keeps track of a host-side OUT pipe whose packet buffer is one bank or two banks used in alternation. The CPU side pushes bytes into the bank it currently points at. It then hands that bank over for transmission with a commit strobe, which clears the "bank free" flag. In two-bank mode the same strobe moves the CPU pointer to the other bank, so the CPU can fill it while the first one is still on the bus or waiting for its handshake.

The bus side sees a send request whenever the bank at the head of the queue is committed. It reads the bytes of that bank by address, up to the stored length, and answers with an ACK pulse once the device has acknowledged. The ACK frees the head bank, resets its byte count, moves the bus pointer on and sets a sticky transmit-complete flag. Software clears that flag through a separate strobe. All flags seen by the CPU are derived from the state of the bank the CPU pointer currently selects. The pipe does nothing while the configuration-valid input is low, and dropping that input clears the whole pipe.

Top module: `outpipe_bank_ctrl`

## Requirements
- R1: After reset, with the pipe unconfigured, bank_free, tx_done and bus_req are 0, and cpu_bank and bus_bank are 0.
- R2: A CPU write into a free bank stores cpu_wr_data at the position equal to that bank's byte count and adds one to the count. Writes beyond BANK_BYTES bytes are dropped, so bus_len never exceeds BANK_BYTES.
- R3: A commit while bank_free is 1 marks the current bank as owned by the bus side. From the next cycle, bus_req is 1 for that bank and bus_len carries its byte count.
- R4: While bank_free is 0, commits and CPU writes have no effect: cpu_bank, bus_len and the stored bytes stay unchanged.
- R5: While cfg_valid is 0, bank_free reads 0 and commits and writes are ignored. Sampling cfg_valid at 0 on a clock edge returns every bank to free with a zero count, resets both pointers to bank 0 and clears tx_done.
- R6: An ACK (bus_ack=1 while bus_req=1) frees the head bank and zeroes its count. On the next cycle tx_done is 1. An ACK while bus_req is 0 is ignored.
- R7: cpu_txc_clr=1 clears tx_done on the next cycle, unless an ACK is taken in the same cycle, in which case tx_done is 1.
- R8: Committing a bank with a count of zero gives bus_req=1 with bus_len=0, a zero-length packet.
- R9: With cfg_two_banks=0, cpu_bank and bus_bank stay 0, and bank_free returns to 1 only after the ACK of the single bank.
- R10: With cfg_two_banks=1, each commit toggles cpu_bank and each ACK toggles bus_bank. Banks therefore go out in commit order, and bank_free shows the state of the newly selected bank.
- R11: bus_rd_data is, combinationally, the byte stored at address bus_rd_addr of the bank selected by bus_bank.
- R12: A CPU write in the same cycle as a commit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Pipe configured; 0 holds the pipe cleared |
| cfg_two_banks | input | 1 | 1 = two banks in alternation, 0 = single bank |
| cpu_wr_en | input | 1 | Write one byte into the current CPU bank |
| cpu_wr_data | input | DATA_W | Byte to write |
| cpu_commit | input | 1 | Hand the current bank to the bus side (clears bank_free) |
| cpu_txc_clr | input | 1 | Clear strobe for tx_done |
| bank_free | output | 1 | 1 = current CPU bank is free for writes |
| cpu_bank | output | 1 | Bank the CPU side currently points at |
| tx_done | output | 1 | Sticky transmit-complete flag, set by an ACK |
| bus_req | output | 1 | Head bank is committed and waiting to be sent |
| bus_bank | output | 1 | Bank at the head of the send queue |
| bus_len | output | $clog2(BANK_BYTES+1) | Byte count of the head bank |
| bus_rd_addr | input | $clog2(BANK_BYTES) | Byte address read by the bus side |
| bus_rd_data | output | DATA_W | Byte at bus_rd_addr in the head bank |
| bus_ack | input | 1 | Device ACK for the head packet |

## Verification
Every stored quantity changes on the clock edge that samples the strobe. So bank_free, cpu_bank, bus_req, bus_bank, bus_len and tx_done first show the effect of a write, commit, ACK, clear or configuration drop one cycle after the strobe is applied. bus_rd_data follows bus_rd_addr in the same cycle. The bench applies inputs just after a falling edge and checks the outputs at the next falling edge, half a period after the edge that acted. A behavioural model, updated on the same rising edge from the same inputs, is compared against all outputs at every falling edge.

// File: rtl/opb_pkg.sv
package opb_pkg;
  localparam int unsigned NUM_BANKS = 2;

  // Pointer step after a commit or an ACK: toggles only in two-bank mode
  function automatic logic next_bank(input logic cur, input logic two_banks);
    return two_banks ? ~cur : cur;
  endfunction

  // Flat storage slot of byte addr inside the given bank
  function automatic int unsigned slot_index(input logic bank, input int unsigned addr,
                                             input int unsigned depth);
    return (bank ? depth : 0) + addr;
  endfunction

  // Whether a bank holding cnt bytes can take one more
  function automatic logic has_room(input int unsigned cnt, input int unsigned depth);
    return cnt < depth;
  endfunction
endpackage

// File: rtl/opb_owner_track.sv
module opb_owner_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_valid,
  input  logic       two_banks,
  input  logic       commit_req,
  input  logic       ack_req,
  output logic [1:0] owned,
  output logic       cpu_ptr,
  output logic       bus_ptr,
  output logic       commit_fire,
  output logic       ack_fire
);
  import opb_pkg::*;

  logic [1:0] owned_nxt;

  // A commit only acts on a free bank; an ACK only on a committed head bank
  assign commit_fire = cfg_valid & commit_req & ~owned[cpu_ptr];
  assign ack_fire    = cfg_valid & ack_req & owned[bus_ptr];

  always_comb begin
    owned_nxt = owned;
    if (commit_fire) owned_nxt[cpu_ptr] = 1'b1;
    if (ack_fire)    owned_nxt[bus_ptr] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned   <= '0;
      cpu_ptr <= 1'b0;
      bus_ptr <= 1'b0;
    end else if (!cfg_valid) begin
      owned   <= '0;
      cpu_ptr <= 1'b0;
      bus_ptr <= 1'b0;
    end else begin
      owned <= owned_nxt;
      if (commit_fire) cpu_ptr <= next_bank(cpu_ptr, two_banks);
      if (ack_fire)    bus_ptr <= next_bank(bus_ptr, two_banks);
    end
  end
endmodule

// File: rtl/opb_bank_store.sv
module opb_bank_store #(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 64,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 wr_en,
  input  logic                 wr_bank,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rel_en,
  input  logic                 rel_bank,
  input  logic                 rd_bank,
  input  logic [AW-1:0]        rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [1:0][CW-1:0]   fill
);
  import opb_pkg::*;

  localparam int SLOTS = NUM_BANKS * DEPTH;
  localparam int SW    = $clog2(SLOTS);

  logic [DATA_W-1:0] mem [SLOTS];
  logic [SW-1:0]     wr_slot;
  logic [SW-1:0]     rd_slot;

  assign wr_slot = SW'(slot_index(wr_bank, 32'(fill[wr_bank]), DEPTH));
  assign rd_slot = SW'(slot_index(rd_bank, 32'(rd_addr), DEPTH));
  assign rd_data = mem[rd_slot];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_data;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_fill
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fill[b] <= '0;
      else if (flush || (rel_en && rel_bank == 1'(b)))
        fill[b] <= '0;
      else if (wr_en && wr_bank == 1'(b))
        fill[b] <= fill[b] + 1'b1;
    end
  end
endmodule

// File: rtl/opb_txc_flag.sv
module opb_txc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic set,
  input  logic clr,
  output logic flag
);
  // Set wins over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (flush) flag <= 1'b0;
    else if (set)   flag <= 1'b1;
    else if (clr)   flag <= 1'b0;
  end
endmodule

// File: rtl/outpipe_bank_ctrl.sv
module outpipe_bank_ctrl #(
  parameter  int DATA_W     = 8,
  parameter  int BANK_BYTES = 64,
  localparam int AW         = $clog2(BANK_BYTES),
  localparam int CW         = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_two_banks,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_commit,
  input  logic              cpu_txc_clr,
  output logic              bank_free,
  output logic              cpu_bank,
  output logic              tx_done,
  output logic              bus_req,
  output logic              bus_bank,
  output logic [CW-1:0]     bus_len,
  input  logic [AW-1:0]     bus_rd_addr,
  output logic [DATA_W-1:0] bus_rd_data,
  input  logic              bus_ack
);
  import opb_pkg::*;

  logic [1:0]         owned;
  logic               cpu_ptr;
  logic               bus_ptr;
  logic               commit_fire;
  logic               ack_fire;
  logic               write_fire;
  logic               room;
  logic [1:0][CW-1:0] fill;

  opb_owner_track u_own (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid   (cfg_valid),
    .two_banks   (cfg_two_banks),
    .commit_req  (cpu_commit),
    .ack_req     (bus_ack),
    .owned       (owned),
    .cpu_ptr     (cpu_ptr),
    .bus_ptr     (bus_ptr),
    .commit_fire (commit_fire),
    .ack_fire    (ack_fire)
  );

  // CPU-visible flag follows the bank the CPU pointer selects
  assign bank_free  = cfg_valid & ~owned[cpu_ptr];
  assign room       = has_room(32'(fill[cpu_ptr]), BANK_BYTES);
  assign write_fire = bank_free & cpu_wr_en & ~cpu_commit & room;

  opb_bank_store #(
    .DATA_W (DATA_W),
    .DEPTH  (BANK_BYTES)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (~cfg_valid),
    .wr_en    (write_fire),
    .wr_bank  (cpu_ptr),
    .wr_data  (cpu_wr_data),
    .rel_en   (ack_fire),
    .rel_bank (bus_ptr),
    .rd_bank  (bus_ptr),
    .rd_addr  (bus_rd_addr),
    .rd_data  (bus_rd_data),
    .fill     (fill)
  );

  opb_txc_flag u_txc (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (~cfg_valid),
    .set   (ack_fire),
    .clr   (cpu_txc_clr),
    .flag  (tx_done)
  );

  assign cpu_bank = cpu_ptr;
  assign bus_bank = bus_ptr;
  assign bus_req  = owned[bus_ptr];
  assign bus_len  = fill[bus_ptr];
endmodule

// File: rtl/outpipe_bank_ctrl_chk.sv
module outpipe_bank_ctrl_chk #(
  parameter  int BANK_BYTES = 64,
  localparam int CW         = $clog2(BANK_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_valid,
  input logic          cfg_two_banks,
  input logic          cpu_txc_clr,
  input logic          bank_free,
  input logic          cpu_bank,
  input logic          tx_done,
  input logic          bus_req,
  input logic          bus_bank,
  input logic [CW-1:0] bus_len,
  input logic          commit_fire,
  input logic          ack_fire
);
  p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bus_len) <= BANK_BYTES);

  p_commit_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> bus_req);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !bank_free) |=> $stable(cpu_bank));

  p_unconf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> !bank_free);

  p_unconf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> (!bus_req && !tx_done));

  p_ack_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> tx_done);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_txc_clr && !ack_fire) |=> !tx_done);

  p_single_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && !cfg_two_banks) |=> !bank_free);

  p_alternate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && cfg_two_banks) |=> (bus_bank != $past(bus_bank)));
endmodule

bind outpipe_bank_ctrl outpipe_bank_ctrl_chk #(.BANK_BYTES(BANK_BYTES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_valid     (cfg_valid),
  .cfg_two_banks (cfg_two_banks),
  .cpu_txc_clr   (cpu_txc_clr),
  .bank_free     (bank_free),
  .cpu_bank      (cpu_bank),
  .tx_done       (tx_done),
  .bus_req       (bus_req),
  .bus_bank      (bus_bank),
  .bus_len       (bus_len),
  .commit_fire   (commit_fire),
  .ack_fire      (ack_fire)
);

// File: tb/outpipe_bank_ctrl_test.sv
module outpipe_bank_ctrl_test;
  localparam int DW = 8;
  localparam int NB = 64;
  localparam int AW = $clog2(NB);
  localparam int CW = $clog2(NB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0, cfg_two_banks = 1'b0;
  logic cpu_wr_en = 1'b0, cpu_commit = 1'b0, cpu_txc_clr = 1'b0, bus_ack = 1'b0;
  logic [DW-1:0] cpu_wr_data = '0;
  logic [AW-1:0] bus_rd_addr = '0;
  logic bank_free, cpu_bank, tx_done, bus_req, bus_bank;
  logic [CW-1:0] bus_len;
  logic [DW-1:0] bus_rd_data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  outpipe_bank_ctrl #(.DATA_W(DW), .BANK_BYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_two_banks(cfg_two_banks),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_commit(cpu_commit),
    .cpu_txc_clr(cpu_txc_clr), .bank_free(bank_free), .cpu_bank(cpu_bank),
    .tx_done(tx_done), .bus_req(bus_req), .bus_bank(bus_bank), .bus_len(bus_len),
    .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data), .bus_ack(bus_ack)
  );

  // Behavioural reference: per-bank ownership, counts and byte arrays
  bit own_m [2];
  int cnt_m [2];
  logic [DW-1:0] data_m [2][NB];
  int cptr_m = 0, bptr_m = 0;
  bit done_m = 0;

  always @(posedge clk) begin
    if (!rst_n || !cfg_valid) begin
      own_m[0] = 0; own_m[1] = 0; cnt_m[0] = 0; cnt_m[1] = 0;
      cptr_m = 0; bptr_m = 0; done_m = 0;
    end else begin
      int c, h;
      bit took_ack, took_commit;
      c = cptr_m; h = bptr_m;
      took_ack = bus_ack && own_m[h];
      took_commit = cpu_commit && !own_m[c];
      if (cpu_wr_en && !cpu_commit && !own_m[c] && cnt_m[c] < NB) begin
        data_m[c][cnt_m[c]] = cpu_wr_data;
        cnt_m[c] = cnt_m[c] + 1;
      end
      if (took_commit) begin
        own_m[c] = 1;
        if (cfg_two_banks) cptr_m = 1 - c;
      end
      if (took_ack) begin
        own_m[h] = 0;
        cnt_m[h] = 0;
        if (cfg_two_banks) bptr_m = 1 - h;
        done_m = 1;
      end else if (cpu_txc_clr) begin
        done_m = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 bank_free vs model", int'(bank_free), int'(cfg_valid && !own_m[cptr_m]));
      chk("R9 cpu_bank vs model", int'(cpu_bank), cptr_m);
      chk("R6 tx_done vs model", int'(tx_done), int'(done_m));
      chk("R10 bus_req vs model", int'(bus_req), int'(own_m[bptr_m]));
      chk("R10 bus_bank vs model", int'(bus_bank), bptr_m);
      if (own_m[bptr_m]) begin
        chk("R2 bus_len vs model", int'(bus_len), cnt_m[bptr_m]);
        if (int'(bus_rd_addr) < cnt_m[bptr_m])
          chk("R11 bus_rd_data vs model", int'(bus_rd_data),
              int'(data_m[bptr_m][bus_rd_addr]));
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic put(input logic [DW-1:0] d);
    cpu_wr_en = 1'b1; cpu_wr_data = d;
    cyc();
    cpu_wr_en = 1'b0;
  endtask

  task automatic commit();
    cpu_commit = 1'b1;
    cyc();
    cpu_commit = 1'b0;
  endtask

  task automatic ack();
    bus_ack = 1'b1;
    cyc();
    bus_ack = 1'b0;
  endtask

  task automatic peek(input int a, input int exp, input string req);
    bus_rd_addr = AW'(a);
    #1;
    chk(req, int'(bus_rd_data), exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1: reset state
    chk("R1 bank_free after reset", int'(bank_free), 0);
    chk("R1 tx_done after reset", int'(tx_done), 0);
    chk("R1 bus_req after reset", int'(bus_req), 0);
    chk("R1 cpu_bank after reset", int'(cpu_bank), 0);
    // R5: ignored while unconfigured
    put(8'h55);
    commit();
    chk("R5 commit ignored unconfigured", int'(bus_req), 0);
    chk("R5 bank_free unconfigured", int'(bank_free), 0);

    // Single-bank mode
    cfg_valid = 1'b1;
    cyc();
    chk("R9 bank free once configured", int'(bank_free), 1);
    put(8'hA1); put(8'hB2); put(8'hC3);
    commit();
    chk("R3 bus_req after commit", int'(bus_req), 1);
    chk("R3 bus_len after commit", int'(bus_len), 3);
    chk("R9 bank owned after commit", int'(bank_free), 0);
    chk("R9 cpu_bank stays 0", int'(cpu_bank), 0);
    peek(1, 8'hB2, "R11 read byte 1");
    // R4: write and commit while busy
    put(8'hEE);
    commit();
    chk("R4 len unchanged while busy", int'(bus_len), 3);
    peek(0, 8'hA1, "R4 byte 0 unchanged while busy");
    chk("R4 bank_free stays 0", int'(bank_free), 0);
    ack();
    chk("R6 tx_done after ack", int'(tx_done), 1);
    chk("R6 bus_req dropped after ack", int'(bus_req), 0);
    chk("R9 bank free after ack", int'(bank_free), 1);
    // R6: stray ack ignored, R7 clear
    cpu_txc_clr = 1'b1;
    cyc();
    cpu_txc_clr = 1'b0;
    chk("R7 tx_done cleared", int'(tx_done), 0);
    ack();
    chk("R6 stray ack ignored", int'(tx_done), 0);
    // R8 zero-length, also shows the count was zeroed by the ack
    commit();
    chk("R8 zero-length req", int'(bus_req), 1);
    chk("R8 zero-length len", int'(bus_len), 0);
    // R7: ack beats clear
    bus_ack = 1'b1; cpu_txc_clr = 1'b1;
    cyc();
    bus_ack = 1'b0; cpu_txc_clr = 1'b0;
    chk("R7 ack wins over clear", int'(tx_done), 1);
    // R2: overfill
    for (int i = 0; i < NB + 2; i++) put(DW'(i));
    commit();
    chk("R2 length saturates", int'(bus_len), NB);
    peek(NB - 1, NB - 1, "R2 last byte stored");
    ack();
    // R12: write with commit is dropped
    cpu_wr_en = 1'b1; cpu_wr_data = 8'h77; cpu_commit = 1'b1;
    cyc();
    cpu_wr_en = 1'b0; cpu_commit = 1'b0;
    chk("R12 write with commit dropped", int'(bus_len), 0);
    ack();

    // Two-bank mode
    cfg_valid = 1'b0;
    cyc();
    cfg_two_banks = 1'b1; cfg_valid = 1'b1;
    cyc();
    chk("R5 tx_done flushed", int'(tx_done), 0);
    chk("R10 start at bank 0", int'(cpu_bank), 0);
    put(8'h11); put(8'h22);
    commit();
    chk("R10 cpu moves to bank 1", int'(cpu_bank), 1);
    chk("R10 bank 1 free", int'(bank_free), 1);
    chk("R10 head is bank 0", int'(bus_bank), 0);
    chk("R10 head len", int'(bus_len), 2);
    for (int i = 0; i < 5; i++) put(DW'(8'h30 + i));
    commit();
    chk("R10 cpu back to bank 0", int'(cpu_bank), 0);
    chk("R10 bank 0 still owned", int'(bank_free), 0);
    chk("R10 head still bank 0", int'(bus_bank), 0);
    ack();
    chk("R10 head moves to bank 1", int'(bus_bank), 1);
    chk("R10 bank 1 len", int'(bus_len), 5);
    chk("R10 bank 0 freed", int'(bank_free), 1);
    peek(4, 8'h34, "R11 read bank 1 byte 4");
    // commit empty bank 0 while acking bank 1
    cpu_commit = 1'b1; bus_ack = 1'b1;
    cyc();
    cpu_commit = 1'b0; bus_ack = 1'b0;
    chk("R10 head wraps to bank 0", int'(bus_bank), 0);
    chk("R8 empty bank queued", int'(bus_req), 1);
    chk("R8 empty bank len", int'(bus_len), 0);
    chk("R10 cpu on bank 1 free", int'(bank_free), 1);
    // R5: drop configuration with work pending
    cfg_valid = 1'b0;
    cyc();
    chk("R5 bus_req cleared", int'(bus_req), 0);
    chk("R5 tx_done cleared", int'(tx_done), 0);
    chk("R5 pointers reset", int'(cpu_bank), 0);
    cfg_valid = 1'b1;
    cyc();
    commit();
    chk("R5 counts cleared", int'(bus_len), 0);
    cyc();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule